// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is a bank of programmable logic cells. Each lane pairs an output cell with a buried cell. A cell takes one sum-of-products term, can invert it, and passes it through a storage element. A configuration word held at the block's input picks how that storage behaves: a straight combinatorial path, an edge-triggered D register, a toggle register, or a level-sensitive latch. The same word picks which of two global clocks drives the storage. Asynchronous clear and set inputs force the stored bit at any time, and clear takes priority when both are active.

The output cell feeds two destinations. One is a pin path, which an output enable can gate off. The other is a feedback path to the routing fabric, and that path stays valid whatever the enable does. The buried cell has no pin and always drives its feedback. One configuration bit turns the buried cell into an input register or input latch. In that mode it samples the pin value of the output cell in its lane, so the register stays usable while that pin serves as an input.

Configuration changes take effect at once. The surrounding logic may switch modes between clock edges.

Top module: `macrocell_bank`

## Requirements
- R1: A cell configuration word is 5 bits: bit 4 input-register select, bit 3 invert, bit 2 clock select, bits 1:0 storage mode (00 bypass, 01 D register, 10 toggle register, 11 latch). Lane i uses bits [5*i+4 : 5*i] of each configuration bus. In bypass mode the cell output equals the (optionally inverted) sum with no clock involved, and lanes are independent.
- R2: When the invert bit is 1, the sum term is complemented before it reaches the storage element, in every storage mode.
- R3: In D register mode the cell output takes the post-polarity sum on the rising edge of the selected clock and does not change between edges.
- R4: In toggle mode the stored bit inverts on each rising edge of the selected clock when the post-polarity sum is 1, and holds when it is 0.
- R5: In latch mode the selected clock is an active-high enable. The output follows the data while the enable is high and holds its last value while the enable is low.
- R6: Clock select 0 chooses clk_a and 1 chooses clk_b. Edges on the clock that is not chosen have no effect on the cell.
- R7: Asynchronous clear forces the stored bit to 0 and asynchronous set forces it to 1, with no clock edge needed. Clear wins when both are active. Bypass mode output does not depend on them.
- R8: The feedback output always carries the cell output. When the output enable is 1, pin_out equals the cell output and pin_en is 1. When it is 0, pin_out is 0 and pin_en is 0.
- R9: A buried cell with the input-register bit set stores the pad_in bit of its own lane, ignoring its sum and invert bit. It behaves as a latch for mode 11 and as a D register for any other mode, on the selected clock.
- R10: A buried cell with the input-register bit clear works like an output cell on its own sum and drives its feedback output with no enable.
- R11: The input-register bit has no effect on an output cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Global clock 0 |
| clk_b | input | 1 | Global clock 1 |
| arst | input | 1 | Asynchronous clear, active high |
| apre | input | 1 | Asynchronous set, active high |
| io_cfg | input | 5*LANES | Output cell configuration words |
| bur_cfg | input | 5*LANES | Buried cell configuration words |
| io_sum | input | LANES | Sum term per output cell |
| bur_sum | input | LANES | Sum term per buried cell |
| pad_in | input | LANES | Value seen on each output cell's pin |
| oe | input | LANES | Output enable per output cell |
| pin_out | output | LANES | Pin data per output cell |
| pin_en | output | LANES | Pin drive enable per output cell |
| io_fb | output | LANES | Feedback from output cells |
| bur_fb | output | LANES | Feedback from buried cells |

## Verification
Each storage mode is driven with a sum that changes both on a clock edge and between edges. A register is told apart from the bypass path and from the latch this way. The toggle test holds the sum at 1 and then at 0 for several edges, which shows toggling versus capture. The latch test changes data while the enable is high and again after it falls. The clock-select test runs only the clock that is not selected, then pulses the selected one. Set and clear are raised between edges, singly and then together, to show that they act asynchronously and that clear has priority. The buried cell is driven with a sum and a pad value that disagree, which shows which source it stores.

// File: rtl/mcell_pkg.sv
`timescale 1ns/100ps
package mcell_pkg;

   typedef enum logic [1:0] {
      SM_BYPASS = 2'b00,
      SM_DFF    = 2'b01,
      SM_TFF    = 2'b10,
      SM_LATCH  = 2'b11
   } store_mode_e;

   typedef struct packed {
      logic        in_reg;
      logic        invert;
      logic        clk_pick;
      store_mode_e mode;
   } cell_cfg_t;

   localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/mcell_store.sv
`timescale 1ns/100ps
module mcell_store
   import mcell_pkg::*;
(
   input  logic        clk_a,
   input  logic        clk_b,
   input  logic        clk_pick,
   input  logic        arst,
   input  logic        apre,
   input  store_mode_e mode,
   input  logic        d,
   output logic        q
);

   logic sel_clk;
   logic ff_q;
   logic lat_q;

   assign sel_clk = clk_pick ? clk_b : clk_a;

   always_ff @(posedge sel_clk or posedge arst or posedge apre) begin
      if (arst)                 ff_q <= 1'b0;
      else if (apre)            ff_q <= 1'b1;
      else if (mode == SM_TFF)  ff_q <= ff_q ^ d;
      else                      ff_q <= d;
   end

   always_latch begin
      if (arst)         lat_q = 1'b0;
      else if (apre)    lat_q = 1'b1;
      else if (sel_clk) lat_q = d;
   end

   always_comb begin
      unique case (mode)
         SM_BYPASS: q = d;
         SM_LATCH:  q = lat_q;
         default:   q = ff_q;
      endcase
   end

   p_dff_capture_r3: assert property (@(posedge clk_a) disable iff (arst || apre)
      (mode == SM_DFF && !clk_pick &&
       $past(mode == SM_DFF && !clk_pick && !arst && !apre)) |-> q == $past(d));

   p_tff_toggle_r4: assert property (@(posedge clk_a) disable iff (arst || apre)
      (mode == SM_TFF && !clk_pick &&
       $past(mode == SM_TFF && !clk_pick && !arst && !apre)) |-> q == ($past(q) ^ $past(d)));

   p_clear_wins_r7: assert property (@(posedge clk_a) disable iff (!arst)
      ($past(arst) && mode != SM_BYPASS && $past(mode) != SM_BYPASS) |-> q == 1'b0);

endmodule

// File: rtl/mcell_io.sv
`timescale 1ns/100ps
module mcell_io
   import mcell_pkg::*;
(
   input  logic      clk_a,
   input  logic      clk_b,
   input  logic      arst,
   input  logic      apre,
   input  cell_cfg_t cfg,
   input  logic      sum,
   input  logic      oe,
   output logic      pin_out,
   output logic      pin_en,
   output logic      fb
);

   logic cell_d;
   logic cell_q;
   logic unused_inreg;

   assign unused_inreg = cfg.in_reg;
   assign cell_d       = sum ^ cfg.invert;

   mcell_store u_store (
      .clk_a    (clk_a),
      .clk_b    (clk_b),
      .clk_pick (cfg.clk_pick),
      .arst     (arst),
      .apre     (apre),
      .mode     (cfg.mode),
      .d        (cell_d),
      .q        (cell_q)
   );

   assign fb      = cell_q;
   assign pin_en  = oe;
   assign pin_out = oe & cell_q;

   p_pin_matches_fb_r8: assert property (@(posedge clk_a) disable iff (arst)
      pin_en |-> pin_out == fb);

endmodule

// File: rtl/mcell_buried.sv
`timescale 1ns/100ps
module mcell_buried
   import mcell_pkg::*;
(
   input  logic      clk_a,
   input  logic      clk_b,
   input  logic      arst,
   input  logic      apre,
   input  cell_cfg_t cfg,
   input  logic      sum,
   input  logic      nb_pin,
   output logic      fb
);

   logic        cell_d;
   store_mode_e eff_mode;

   always_comb begin
      if (cfg.in_reg) begin
         cell_d   = nb_pin;
         eff_mode = (cfg.mode == SM_LATCH) ? SM_LATCH : SM_DFF;
      end else begin
         cell_d   = sum ^ cfg.invert;
         eff_mode = cfg.mode;
      end
   end

   mcell_store u_store (
      .clk_a    (clk_a),
      .clk_b    (clk_b),
      .clk_pick (cfg.clk_pick),
      .arst     (arst),
      .apre     (apre),
      .mode     (eff_mode),
      .d        (cell_d),
      .q        (fb)
   );

   p_inreg_capture_r9: assert property (@(posedge clk_a) disable iff (arst || apre)
      (cfg.in_reg && cfg.mode != SM_LATCH && !cfg.clk_pick &&
       $past(cfg.in_reg && cfg.mode != SM_LATCH && !cfg.clk_pick && !arst && !apre))
      |-> fb == $past(nb_pin));

endmodule

// File: rtl/macrocell_bank.sv
`timescale 1ns/100ps
module macrocell_bank
   import mcell_pkg::*;
#(
   parameter int LANES      = 2,
   parameter bit HAS_BURIED = 1'b1
) (
   input  logic                   clk_a,
   input  logic                   clk_b,
   input  logic                   arst,
   input  logic                   apre,
   input  logic [LANES*CFG_W-1:0] io_cfg,
   input  logic [LANES*CFG_W-1:0] bur_cfg,
   input  logic [LANES-1:0]       io_sum,
   input  logic [LANES-1:0]       bur_sum,
   input  logic [LANES-1:0]       pad_in,
   input  logic [LANES-1:0]       oe,
   output logic [LANES-1:0]       pin_out,
   output logic [LANES-1:0]       pin_en,
   output logic [LANES-1:0]       io_fb,
   output logic [LANES-1:0]       bur_fb
);

   if (LANES < 1 || LANES > 256) begin : g_bad_lanes
      $error("macrocell_bank: LANES must lie in 1..256");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      mcell_io u_io (
         .clk_a   (clk_a),
         .clk_b   (clk_b),
         .arst    (arst),
         .apre    (apre),
         .cfg     (cell_cfg_t'(io_cfg[i*CFG_W +: CFG_W])),
         .sum     (io_sum[i]),
         .oe      (oe[i]),
         .pin_out (pin_out[i]),
         .pin_en  (pin_en[i]),
         .fb      (io_fb[i])
      );

      if (HAS_BURIED) begin : g_bur
         mcell_buried u_bur (
            .clk_a  (clk_a),
            .clk_b  (clk_b),
            .arst   (arst),
            .apre   (apre),
            .cfg    (cell_cfg_t'(bur_cfg[i*CFG_W +: CFG_W])),
            .sum    (bur_sum[i]),
            .nb_pin (pad_in[i]),
            .fb     (bur_fb[i])
         );
      end else begin : g_nobur
         logic unused_bur;
         assign unused_bur = ^{bur_cfg[i*CFG_W +: CFG_W], bur_sum[i], pad_in[i]};
         assign bur_fb[i]  = 1'b0;
      end
   end

endmodule

// File: tb/sim_macrocell_bank.sv
`timescale 1ns/100ps
module sim_macrocell_bank;

   localparam int LANES = 2;
   localparam int CW    = 5;

   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic arst  = 1'b1;
   logic apre  = 1'b0;
   logic [LANES*CW-1:0] io_cfg  = '0;
   logic [LANES*CW-1:0] bur_cfg = '0;
   logic [LANES-1:0] io_sum = '0, bur_sum = '0, pad_in = '0, oe = '0;
   logic [LANES-1:0] pin_out, pin_en, io_fb, bur_fb;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk_a = ~clk_a;

   macrocell_bank #(.LANES(LANES), .HAS_BURIED(1'b1)) u0 (
      .clk_a(clk_a), .clk_b(clk_b), .arst(arst), .apre(apre),
      .io_cfg(io_cfg), .bur_cfg(bur_cfg), .io_sum(io_sum), .bur_sum(bur_sum),
      .pad_in(pad_in), .oe(oe), .pin_out(pin_out), .pin_en(pin_en),
      .io_fb(io_fb), .bur_fb(bur_fb)
   );

   function automatic logic [4:0] mk(input logic inr, input logic inv,
                                     input logic pick, input logic [1:0] md);
      return {inr, inv, pick, md};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk_a);
   endtask

   task automatic t_reset();
      io_cfg  = {mk(0,0,0,2'b01), mk(0,0,0,2'b01)};
      bur_cfg = {mk(0,0,0,2'b01), mk(0,0,0,2'b01)};
      io_sum = '1; bur_sum = '1;
      repeat (3) step();
      chk("R7 reset io_fb", io_fb[0], 1'b0);
      chk("R7 reset bur_fb", bur_fb[0], 1'b0);
      chk("R8 reset pin_en", pin_en[0], 1'b0);
      arst = 1'b0;
   endtask

   task automatic t_comb();
      step();
      io_cfg = {mk(0,0,0,2'b00), mk(0,0,0,2'b00)};
      io_sum = 2'b01;
      #1 chk("R1 bypass lane0", io_fb[0], 1'b1);
      chk("R1 bypass lane1", io_fb[1], 1'b0);
      io_sum[0] = 1'b0;
      #0.5 chk("R1 bypass follows", io_fb[0], 1'b0);
      io_cfg[3] = 1'b1;
      #0.5 chk("R2 invert bypass", io_fb[0], 1'b1);
   endtask

   task automatic t_dff();
      step();
      io_cfg[4:0] = mk(0,0,0,2'b01);
      io_sum[0] = 1'b1;
      step();
      chk("R3 capture 1", io_fb[0], 1'b1);
      io_sum[0] = 1'b0;
      #1 chk("R3 hold between edges", io_fb[0], 1'b1);
      step();
      chk("R3 capture 0", io_fb[0], 1'b0);
      io_cfg[3] = 1'b1;
      step();
      chk("R2 invert before register", io_fb[0], 1'b1);
   endtask

   task automatic t_tff();
      step();
      io_cfg[4:0] = mk(0,0,0,2'b10);
      io_sum[0] = 1'b0;
      arst = 1'b1;
      step();
      arst = 1'b0;
      io_sum[0] = 1'b1;
      step(); chk("R4 toggle to 1", io_fb[0], 1'b1);
      step(); chk("R4 toggle to 0", io_fb[0], 1'b0);
      step(); chk("R4 toggle to 1 again", io_fb[0], 1'b1);
      io_sum[0] = 1'b0;
      step(); chk("R4 hold a", io_fb[0], 1'b1);
      step(); chk("R4 hold b", io_fb[0], 1'b1);
      io_cfg[3] = 1'b1;
      step(); chk("R4 inverted zero toggles", io_fb[0], 1'b0);
   endtask

   task automatic t_latch();
      step();
      clk_b = 1'b0;
      io_cfg[4:0] = mk(0,0,1,2'b11);
      io_sum[0] = 1'b1;
      arst = 1'b1;
      #1 chk("R7 clear latch", io_fb[0], 1'b0);
      step();
      arst = 1'b0;
      #0.5 chk("R5 enable low holds", io_fb[0], 1'b0);
      clk_b = 1'b1;
      #0.5 chk("R5 transparent 1", io_fb[0], 1'b1);
      io_sum[0] = 1'b0;
      #0.3 chk("R5 transparent 0", io_fb[0], 1'b0);
      io_sum[0] = 1'b1;
      #0.3 clk_b = 1'b0;
      #0.2 io_sum[0] = 1'b0;
      #0.3 chk("R5 hold after fall", io_fb[0], 1'b1);
   endtask

   task automatic t_clksel();
      step();
      clk_b = 1'b0;
      io_cfg[4:0] = mk(0,0,1,2'b01);
      io_sum[0] = 1'b1;
      arst = 1'b1;
      step();
      arst = 1'b0;
      step(); step();
      chk("R6 clk_a ignored", io_fb[0], 1'b0);
      clk_b = 1'b1;
      #0.5 clk_b = 1'b0;
      #0.5 chk("R6 clk_b edge captures", io_fb[0], 1'b1);
      step();
      io_cfg[4:0] = mk(0,0,0,2'b01);
      io_sum[0] = 1'b0;
      #0.3 clk_b = 1'b1;
      #0.3 clk_b = 1'b0;
      #0.3 chk("R6 clk_b ignored", io_fb[0], 1'b1);
      step();
      chk("R6 clk_a captures", io_fb[0], 1'b0);
   endtask

   task automatic t_async();
      step();
      io_cfg[4:0] = mk(0,0,0,2'b01);
      io_sum[0] = 1'b0;
      step();
      #0.5 apre = 1'b1;
      #0.5 chk("R7 async set", io_fb[0], 1'b1);
      arst = 1'b1;
      #0.3 chk("R7 clear wins", io_fb[0], 1'b0);
      step();
      chk("R7 clear wins over edge", io_fb[0], 1'b0);
      arst = 1'b0;
      apre = 1'b0;
      step();
      chk("R7 normal after release", io_fb[0], 1'b0);
      io_cfg[4:0] = mk(0,0,0,2'b00);
      io_sum[0] = 1'b1;
      arst = 1'b1;
      #0.5 chk("R7 bypass ignores clear", io_fb[0], 1'b1);
      step();
      arst = 1'b0;
   endtask

   task automatic t_oe();
      step();
      io_cfg = {mk(0,0,0,2'b00), mk(0,0,0,2'b00)};
      io_sum = 2'b11;
      oe = 2'b00;
      #1 chk("R8 pin gated", pin_out[0], 1'b0);
      chk("R8 pin_en low", pin_en[0], 1'b0);
      chk("R8 fb valid while gated", io_fb[0], 1'b1);
      oe = 2'b01;
      #0.5 chk("R8 pin driven", pin_out[0], 1'b1);
      chk("R8 pin_en high", pin_en[0], 1'b1);
      chk("R8 lane1 still gated", pin_en[1], 1'b0);
   endtask

   task automatic t_inreg();
      step();
      bur_cfg[4:0] = mk(1,1,0,2'b01);
      bur_sum[0] = 1'b1;
      pad_in[0] = 1'b1;
      step();
      chk("R9 input reg takes pad 1", bur_fb[0], 1'b1);
      pad_in[0] = 1'b0;
      step();
      chk("R9 input reg takes pad 0", bur_fb[0], 1'b0);
      clk_b = 1'b0;
      bur_cfg[4:0] = mk(1,1,1,2'b11);
      pad_in[0] = 1'b1;
      #0.5 chk("R9 input latch closed", bur_fb[0], 1'b0);
      clk_b = 1'b1;
      #0.5 chk("R9 input latch open", bur_fb[0], 1'b1);
      clk_b = 1'b0;
      #0.2 pad_in[0] = 1'b0;
      #0.3 chk("R9 input latch holds", bur_fb[0], 1'b1);
   endtask

   task automatic t_buried_logic();
      step();
      bur_cfg[4:0] = mk(0,0,0,2'b00);
      bur_sum[0] = 1'b1;
      pad_in[0] = 1'b0;
      oe[0] = 1'b0;
      #1 chk("R10 buried uses sum", bur_fb[0], 1'b1);
      bur_cfg[3] = 1'b1;
      #0.5 chk("R10 buried invert", bur_fb[0], 1'b0);
   endtask

   task automatic t_io_inreg();
      step();
      io_cfg[4:0] = mk(1,0,0,2'b00);
      io_sum[0] = 1'b1;
      pad_in[0] = 1'b0;
      #1 chk("R11 io ignores in_reg", io_fb[0], 1'b1);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_comb();
      t_dff();
      t_tff();
      t_latch();
      t_clksel();
      t_async();
      t_oe();
      t_inreg();
      t_buried_logic();
      t_io_inreg();
      step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule